// File: doc/BRIEF.md
# Lookahead One-Hot Priority Encoder

This block takes a vector of N request lines and grants exactly one of them: the asserted request with the lowest index. Bit 0 is the most urgent. The grant comes out as a one-hot vector, together with the binary position of the winner and a flag that says whether any request was present. Typical users are arbiters, free-slot finders and match-line resolvers. They present a request vector every cycle and read a registered grant two edges later.

The request vector is cut into 8-bit macros, and each macro is cut into two 4-bit halves. The lower half of a macro produces a mid-level lookahead that blocks the upper half. Each macro also produces a local "any request" term. A lookahead network combines those terms, so that any macro with a lower-indexed request is switched off. The `FOLD` parameter picks the network:
- **Ripple:** each macro hands its lookahead to the next one.
- **Folded:** macros are paired. A pair-level lookahead skips whole pairs, so the first macro's term reaches the second and fourth macros directly, without passing through the third.

Both variants give identical results.

The request vector is sampled into a register, and the encoder outputs are registered again. The combinational path therefore settles inside one cycle and is never seen partway through a transition.

Top module: `la_prio_encoder`

## Requirements
- R1: Grant bit i is 1 exactly when request bit i was 1 and every request bit below i was 0. At most one grant bit is ever set.
- R2: A request vector present at the inputs before rising edge k shows up on `grant`, `index` and `valid` after rising edge k+1, and not before.
- R3: While `rst` is high at a rising edge, the request register and all outputs clear to zero at that edge.
- R4: `valid` is 1 when at least one sampled request bit is 1. With no request, `valid`, `grant` and `index` are all 0.
- R5: `index` is the unsigned binary position (0 = least significant bit) of the single set bit of `grant`.
- R6: Macro m covers request bits 8m..8m+7. The lookahead entering macro m equals the OR of all request bits below 8m, and is 0 for macro 0. A macro whose entering lookahead is high drives all eight of its grant bits to 0.
- R7: Inside a macro, the upper four grant bits (8m+4..8m+7) are all 0 whenever any of bits 8m..8m+3 is set or the macro's entering lookahead is high.
- R8: `FOLD`=0 (ripple) and `FOLD`=1 (paired skip) give identical grant, index and valid for every request pattern, for N=32 and N=64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request vector, bit 0 most urgent |
| grant | output | N | Registered one-hot grant |
| index | output | log2(N) | Registered binary position of the grant |
| valid | output | 1 | Registered: some request was set |

## Verification
The hardest case to reach from the ports is a lookahead that travels a long way: a single request in the lowest macro must suppress requests sitting in every higher macro. In the folded network that path crosses a pair boundary, where the skip term and the in-pair term meet. The bench aims at this by setting pairs of bits: one low bit in an early macro, and a second bit in each later macro, including the third and fourth macros, where the folded and ripple routes differ. It also sets the lower and upper halves of one macro together, to exercise the mid-level lookahead. Four instances (32 and 64 bits, each with and without folding) share the same stimulus, and each is compared against a scan-from-bit-0 model.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int MACRO_W = 8;
  localparam int HALF_W  = 4;

  // Width of a binary index able to address n positions (at least 1)
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  // Number of 8-bit macros for an n-bit request vector
  function automatic int macro_count(input int n);
    return n / MACRO_W;
  endfunction

  // Number of macro pairs used by the folded network
  function automatic int pair_count(input int nm);
    return (nm + 1) / 2;
  endfunction
endpackage

// File: rtl/pe_half4.sv
module pe_half4 (
  input  logic [3:0] req,
  input  logic       blk,
  output logic [3:0] grant,
  output logic       any
);
  // First-set scan within four bits, suppressed when blk is high
  for (genvar j = 0; j < 4; j++) begin : g_bit
    if (j == 0) begin : g_first
      assign grant[j] = req[j] & ~blk;
    end else begin : g_rest
      assign grant[j] = req[j] & ~blk & ~(|req[j-1:0]);
    end
  end

  assign any = |req;
endmodule

// File: rtl/pe_macro8.sv
module pe_macro8 (
  input  logic [7:0] req,
  input  logic       la_in,
  output logic [7:0] grant,
  output logic       any,
  output logic       la_mid
);
  logic lo_any, hi_any;

  pe_half4 u_lo (
    .req  (req[3:0]),
    .blk  (la_in),
    .grant(grant[3:0]),
    .any  (lo_any)
  );

  // Mid-level lookahead: lower half or anything below this macro
  assign la_mid = lo_any | la_in;

  pe_half4 u_hi (
    .req  (req[7:4]),
    .blk  (la_mid),
    .grant(grant[7:4]),
    .any  (hi_any)
  );

  assign any = lo_any | hi_any;

  always_comb begin
    if (la_in) AST_MACRO_BLOCKED: assert (grant == 8'h00);     // R6
    if (la_mid) AST_UPPER_BLOCKED: assert (grant[7:4] == 4'h0); // R7
  end
endmodule

// File: rtl/pe_lookahead_net.sv
module pe_lookahead_net #(
  parameter int NM   = 8,
  parameter bit FOLD = 1'b1
) (
  input  logic [NM-1:0] mac_any,
  output logic [NM-1:0] la_in
);
  localparam int NP = pe_pkg::pair_count(NM);

  if (FOLD == 1'b0) begin : g_ripple
    // Each macro hands its lookahead to the next
    assign la_in[0] = 1'b0;
    for (genvar i = 1; i < NM; i++) begin : g_step
      assign la_in[i] = la_in[i-1] | mac_any[i-1];
    end
  end else begin : g_fold
    // Pair-level lookahead skips whole pairs of macros
    logic [NP-1:0] pair_la;
    assign pair_la[0] = 1'b0;
    for (genvar k = 1; k < NP; k++) begin : g_pair
      assign pair_la[k] = pair_la[k-1] | mac_any[2*k-2] | mac_any[2*k-1];
    end
    for (genvar i = 0; i < NM; i++) begin : g_mac
      if (i % 2 == 0) begin : g_even
        assign la_in[i] = pair_la[i/2];
      end else begin : g_odd
        assign la_in[i] = pair_la[i/2] | mac_any[i-1];
      end
    end

    // Cross-check against a plain ripple of the same terms
    logic [NM-1:0] ref_la;
    assign ref_la[0] = 1'b0;
    for (genvar i = 1; i < NM; i++) begin : g_ref
      assign ref_la[i] = ref_la[i-1] | mac_any[i-1];
    end
    always_comb begin
      AST_FOLD_EQUIV: assert (ref_la == la_in); // R8
    end
  end
endmodule

// File: rtl/pe_onehot2bin.sv
module pe_onehot2bin #(
  parameter int N = 64
) (
  input  logic [N-1:0]                     onehot,
  output logic [pe_pkg::idx_width(N)-1:0]  index
);
  localparam int IW = pe_pkg::idx_width(N);

  function automatic logic [IW-1:0] oh_to_bin(input logic [N-1:0] oh);
    logic [IW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) acc = acc | IW'(i);
    end
    return acc;
  endfunction

  assign index = oh_to_bin(onehot);
endmodule

// File: rtl/la_prio_encoder.sv
module la_prio_encoder #(
  parameter int N    = 64,
  parameter bit FOLD = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N-1:0]                    req,
  output logic [N-1:0]                    grant,
  output logic [pe_pkg::idx_width(N)-1:0] index,
  output logic                            valid
);
  localparam int NM = pe_pkg::macro_count(N);
  localparam int IW = pe_pkg::idx_width(N);

  initial begin
    AST_WIDTH_OK: assert (N % pe_pkg::MACRO_W == 0 && N >= pe_pkg::MACRO_W); // R6
  end

  logic [N-1:0]  req_q;
  logic [N-1:0]  grant_c;
  logic [NM-1:0] mac_any;
  logic [NM-1:0] mac_la;
  logic [NM-1:0] mac_mid;
  logic [IW-1:0] idx_c;
  logic          valid_c;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req;
  end

  pe_lookahead_net #(.NM(NM), .FOLD(FOLD)) u_net (
    .mac_any(mac_any),
    .la_in  (mac_la)
  );

  for (genvar m = 0; m < NM; m++) begin : g_macro
    pe_macro8 u_mac (
      .req   (req_q[8*m +: 8]),
      .la_in (mac_la[m]),
      .grant (grant_c[8*m +: 8]),
      .any   (mac_any[m]),
      .la_mid(mac_mid[m])
    );
    // Entering lookahead equals OR of every lower request
    if (m == 0) begin : g_first
      always_comb AST_LA_FIRST: assert (mac_la[0] == 1'b0); // R6
    end else begin : g_later
      always_comb AST_LA_PREFIX: assert (mac_la[m] == |req_q[8*m-1:0]); // R6
    end
  end

  pe_onehot2bin #(.N(N)) u_enc (
    .onehot(grant_c),
    .index (idx_c)
  );

  assign valid_c = |mac_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= '0;
      index <= '0;
      valid <= 1'b0;
    end else begin
      grant <= grant_c;
      index <= idx_c;
      valid <= valid_c;
    end
  end

  AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R1
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
    valid == (grant != '0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (grant == '0 && index == '0)); // R4
  AST_INDEX_POINTS: assert property (@(posedge clk) disable iff (rst)
    valid |-> grant[index]); // R5
  AST_TWO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (valid == $past(|req, 2))); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (grant == '0 && index == '0 && !valid)); // R3
endmodule

// File: tb/la_prio_encoder_test.sv
`timescale 1ns/1ps
module la_prio_encoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] req = '0;

  logic [63:0] g64f, g64r;
  logic [31:0] g32f, g32r;
  logic [5:0]  i64f, i64r;
  logic [4:0]  i32f, i32r;
  logic        v64f, v64r, v32f, v32r;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  la_prio_encoder #(.N(64), .FOLD(1'b1)) uut (
    .clk(clk), .rst(rst), .req(req), .grant(g64f), .index(i64f), .valid(v64f));
  la_prio_encoder #(.N(64), .FOLD(1'b0)) uut_64r (
    .clk(clk), .rst(rst), .req(req), .grant(g64r), .index(i64r), .valid(v64r));
  la_prio_encoder #(.N(32), .FOLD(1'b1)) uut_32f (
    .clk(clk), .rst(rst), .req(req[31:0]), .grant(g32f), .index(i32f), .valid(v32f));
  la_prio_encoder #(.N(32), .FOLD(1'b0)) uut_32r (
    .clk(clk), .rst(rst), .req(req[31:0]), .grant(g32r), .index(i32r), .valid(v32r));

  // Reference: scan upward from bit 0 over the low w bits
  task automatic ref_model(input logic [63:0] v, input int w,
                           output logic [63:0] eg, output int ei, output bit ev);
    eg = '0; ei = 0; ev = 1'b0;
    for (int i = 0; i < w; i++) begin
      if (!ev && v[i]) begin
        eg[i] = 1'b1; ei = i; ev = 1'b1;
      end
    end
  endtask

  task automatic check_one(input string tag, input string name,
                           input logic [63:0] ag, input int ai, input bit av,
                           input logic [63:0] v, input int w);
    logic [63:0] eg; int ei; bit ev;
    ref_model(v, w, eg, ei, ev);
    n_checks++;
    if (ag !== eg || ai != ei || av !== ev) begin
      n_fail++;
      $display("FAIL %s %s: got grant=%h index=%0d valid=%0b expected grant=%h index=%0d valid=%0b",
               tag, name, ag, ai, av, eg, ei, ev);
    end
  endtask

  task automatic check_all(input string tag, input logic [63:0] v);
    check_one(tag, "n64_fold",   g64f,        int'(i64f), v64f, v, 64);
    check_one(tag, "n64_ripple", g64r,        int'(i64r), v64r, v, 64);
    check_one(tag, "n32_fold",   {32'h0,g32f}, int'(i32f), v32f, v, 32);
    check_one(tag, "n32_ripple", {32'h0,g32r}, int'(i32r), v32r, v, 32);
  endtask

  // Drive at a falling edge, result after two rising edges
  task automatic apply(input string tag, input logic [63:0] v);
    @(negedge clk) req = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_all(tag, v);
  endtask

  task automatic t_reset();
    rst = 1'b1; req = '1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check_all("R3 reset", 64'h0);
    rst = 1'b0; req = '0;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic t_zero();
    apply("R4 no request", 64'h0);
  endtask

  task automatic t_all_ones();
    apply("R1 all ones", '1);
  endtask

  task automatic t_walk();
    for (int p = 0; p < 64; p++) apply("R5 single bit walk", 64'h1 << p);
  endtask

  task automatic t_msb();
    apply("R6 only msb64", 64'h1 << 63);
    apply("R6 only msb32", 64'h1 << 31);
  endtask

  task automatic t_latency();
    logic [63:0] v;
    v = 64'h0000_0100_0000_0000;
    apply("R2 baseline zero", 64'h0);
    @(negedge clk) req = v;
    @(posedge clk);
    @(negedge clk);
    check_all("R2 still old after one edge", 64'h0);
    @(posedge clk);
    @(negedge clk);
    check_all("R2 new after two edges", v);
  endtask

  task automatic t_cross_macro();
    // Low bit in macro a plus a bit in each later macro b
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        apply("R6 lower macro blocks higher",
              (64'h1 << (8*a + 7)) | (64'h1 << (8*b)) | (64'h1 << (8*b + 5)));
      end
    end
  endtask

  task automatic t_halves();
    for (int m = 0; m < 8; m++) begin
      apply("R7 lower half wins", (64'hF0 | (64'h1 << 3)) << (8*m));
      apply("R7 upper half alone", 64'h60 << (8*m));
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++) begin
      logic [63:0] v;
      v = {$urandom(), $urandom()};
      if (k % 3 == 1) v = v & (v << 7) & (v << 19);
      if (k % 3 == 2) v = v & ~((64'h1 << (k % 60)) - 1);
      apply("R8 random fold vs ripple", v);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_zero();
    t_all_ones();
    t_walk();
    t_msb();
    t_latency();
    t_cross_macro();
    t_halves();
    t_random();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule